// File: doc/BRIEF.md
# Reorder Buffer Vulnerability Throttle

This unit keeps a running total of reorder-buffer bits that currently hold architecturally live state, which are the bits a particle strike could corrupt with visible effect. It updates the total every cycle from four kinds of pipeline event. An allocation charges the entry's header bits. A result write charges the entry's result bits. Retirement and wrong-path squash release whatever the affected entries had been charged. A global flush releases everything at once.

The unit compares the total against a programmable ceiling. It raises a dispatch hold whenever admitting one more instruction would push the total above that ceiling. Result writes cannot be held back. For that reason a conservative mode charges header and result bits together at allocation time, so later result writes never move the total.

Software or a policy block sets the ceiling. The pipeline simply respects the hold. The per-entry bookkeeping is two bits: a live flag and a result-charged flag.

Top module: `rob_vuln_throttle`

## Requirements
- R1: After reset `vuln_count` is 0 and no entry is live.
- R2: In normal mode (`cfg_conservative`=0), an accepted dispatch to an entry that is not live adds HDR_BITS to the count and makes the entry live.
- R3: In conservative mode (`cfg_conservative`=1), an accepted dispatch adds HDR_BITS+RES_BITS and marks the entry as already result-charged.
- R4: A writeback to a live entry that is not yet result-charged adds RES_BITS once. Any further writeback to it adds nothing.
- R5: A commit of a live entry subtracts HDR_BITS, plus RES_BITS if the entry was result-charged, and makes the entry not live.
- R6: A squash releases every live entry whose bit is set in `squash_mask` (bit i selects entry i), each by the same amount as a commit.
- R7: `disp_stall` is high exactly when the current count plus the dispatch charge of the present mode exceeds `cfg_bound`. A charge that lands exactly on the bound is allowed. A stalled dispatch changes nothing.
- R8: Dispatch, writeback, commit and squash in the same cycle are all applied together in one update. A writeback and a release of the same entry in the same cycle net to releasing header plus result bits.
- R9: `flush_all` returns the count to 0 on the next edge and clears every entry, overriding all other events in that cycle.
- R10: Writeback, commit and squash of an entry that is not live, and dispatch to an entry that is already live, have no effect on the count.
- R11: In conservative mode a writeback never changes the count, so with a fixed bound the count stays at or below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bound | input | CNT_W | Ceiling on the vulnerable-bit total |
| cfg_conservative | input | 1 | 1: charge the whole entry at dispatch |
| disp_req | input | 1 | Dispatch attempt this cycle |
| disp_idx | input | IDX_W | Entry being allocated |
| wb_vld | input | 1 | Result write this cycle |
| wb_idx | input | IDX_W | Entry receiving the result |
| cmt_vld | input | 1 | Retirement this cycle |
| cmt_idx | input | IDX_W | Entry retiring |
| squash_mask | input | ENTRIES | Entries discarded as wrong-path |
| flush_all | input | 1 | Discard all entries |
| disp_stall | output | 1 | Dispatch hold |
| vuln_count | output | CNT_W | Current vulnerable-bit total |

## Verification
`disp_stall` is combinational: it reflects the current count and mode in the same cycle the inputs are presented. `vuln_count` is registered and shows the effect of a cycle's events one edge later. The bench drives events on the falling edge and compares the hold shortly after, against a reference taken before the rising edge. After the edge, the new count is compared with the reference's updated total, both in the next cycle's comparison and in directed checks made at the following falling edge. A long run of mixed random events, with the ceiling and the mode changing, checks both outputs against the reference on every cycle.

// File: rtl/rob_vuln_throttle.sv
module rob_vuln_throttle #(
  parameter int ENTRIES  = 16,
  parameter int HDR_BITS = 64,
  parameter int RES_BITS = 64,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int ENT_BITS = HDR_BITS + RES_BITS,
  localparam int CNT_W   = $clog2(ENTRIES * ENT_BITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cfg_bound,
  input  logic               cfg_conservative,
  input  logic               disp_req,
  input  logic [IDX_W-1:0]   disp_idx,
  input  logic               wb_vld,
  input  logic [IDX_W-1:0]   wb_idx,
  input  logic               cmt_vld,
  input  logic [IDX_W-1:0]   cmt_idx,
  input  logic [ENTRIES-1:0] squash_mask,
  input  logic               flush_all,
  output logic               disp_stall,
  output logic [CNT_W-1:0]   vuln_count
);

  localparam logic [CNT_W:0] CH_HDR = (CNT_W+1)'(HDR_BITS);
  localparam logic [CNT_W:0] CH_RES = (CNT_W+1)'(RES_BITS);
  localparam logic [CNT_W:0] CH_ENT = (CNT_W+1)'(ENT_BITS);

  logic [ENTRIES-1:0] live_q, rchg_q;
  logic [ENTRIES-1:0] wb_hit, kill, disp_hit;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W:0]     charge, cand, inc, dec, cnt_nxt;
  logic               disp_go;

  assign charge     = cfg_conservative ? CH_ENT : CH_HDR;
  assign cand       = {1'b0, cnt_q} + charge;
  assign disp_stall = cand > {1'b0, cfg_bound};
  assign disp_go    = disp_req & ~disp_stall & ~flush_all;
  assign vuln_count = cnt_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign wb_hit[i]   = wb_vld & (wb_idx == IDX_W'(i)) & live_q[i] & ~rchg_q[i];
    assign kill[i]     = live_q[i] & ((cmt_vld & (cmt_idx == IDX_W'(i))) | squash_mask[i]);
    assign disp_hit[i] = disp_go & (disp_idx == IDX_W'(i)) & ~live_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[i] <= 1'b0;
        rchg_q[i] <= 1'b0;
      end else if (flush_all || kill[i]) begin
        live_q[i] <= 1'b0;
        rchg_q[i] <= 1'b0;
      end else if (disp_hit[i]) begin
        live_q[i] <= 1'b1;
        rchg_q[i] <= cfg_conservative;
      end else if (wb_hit[i]) begin
        rchg_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    inc = (|disp_hit) ? charge : '0;
    dec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (wb_hit[i]) inc = inc + CH_RES;
      if (kill[i])   dec = dec + CH_HDR + ((rchg_q[i] | wb_hit[i]) ? CH_RES : '0);
    end
    cnt_nxt = {1'b0, cnt_q} + inc - dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (flush_all) cnt_q <= '0;
    else                cnt_q <= cnt_nxt[CNT_W-1:0];
  end

endmodule

// File: rtl/rob_vuln_throttle_chk.sv
module rob_vuln_throttle_chk #(
  parameter int ENTRIES  = 16,
  parameter int HDR_BITS = 64,
  parameter int RES_BITS = 64,
  localparam int CNT_W   = $clog2(ENTRIES * (HDR_BITS + RES_BITS) + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_req,
  input logic               wb_vld,
  input logic               cmt_vld,
  input logic [ENTRIES-1:0] squash_mask,
  input logic               flush_all,
  input logic               disp_stall,
  input logic [CNT_W-1:0]   vuln_count
);

  // R9
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> vuln_count == '0);

  // R7
  stall_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_stall && !wb_vld && !flush_all) |=> vuln_count <= $past(vuln_count));

  // R5
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_req && !wb_vld) |=> vuln_count <= $past(vuln_count));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_req && !wb_vld && !cmt_vld && squash_mask == '0 && !flush_all) |=> $stable(vuln_count));

  // R3
  step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_vld && !flush_all) |=> vuln_count <= $past(vuln_count) + CNT_W'(HDR_BITS + RES_BITS));

endmodule

bind rob_vuln_throttle rob_vuln_throttle_chk #(
  .ENTRIES(ENTRIES), .HDR_BITS(HDR_BITS), .RES_BITS(RES_BITS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .wb_vld(wb_vld),
  .cmt_vld(cmt_vld), .squash_mask(squash_mask), .flush_all(flush_all),
  .disp_stall(disp_stall), .vuln_count(vuln_count)
);

// File: tb/rob_vuln_throttle_tb_top.sv
module rob_vuln_throttle_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int HB = 64;
  localparam int RB = 64;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N * (HB + RB) + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_bound = '1;
  logic          cfg_conservative = 1'b0;
  logic          disp_req = 1'b0, wb_vld = 1'b0, cmt_vld = 1'b0, flush_all = 1'b0;
  logic [IW-1:0] disp_idx = '0, wb_idx = '0, cmt_idx = '0;
  logic [N-1:0]  squash_mask = '0;
  logic          disp_stall;
  logic [CW-1:0] vuln_count;

  int checks = 0, fails = 0;
  int m_cnt = 0;
  bit m_live[N];
  bit m_rchg[N];

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_vuln_throttle #(.ENTRIES(N), .HDR_BITS(HB), .RES_BITS(RB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bound(cfg_bound), .cfg_conservative(cfg_conservative),
    .disp_req(disp_req), .disp_idx(disp_idx), .wb_vld(wb_vld), .wb_idx(wb_idx),
    .cmt_vld(cmt_vld), .cmt_idx(cmt_idx), .squash_mask(squash_mask),
    .flush_all(flush_all), .disp_stall(disp_stall), .vuln_count(vuln_count));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    int chg, delta;
    bit stl, old_live[N];
    #1;
    chg = cfg_conservative ? HB + RB : HB;
    stl = (m_cnt + chg) > int'(cfg_bound);
    check({tag, " stall"}, int'(disp_stall), int'(stl));
    check({tag, " count"}, int'(vuln_count), m_cnt);
    if (flush_all) begin
      m_cnt = 0;
      for (int i = 0; i < N; i++) begin m_live[i] = 0; m_rchg[i] = 0; end
    end else begin
      delta = 0;
      old_live = m_live;
      for (int i = 0; i < N; i++) begin
        bit w, k;
        w = wb_vld && (int'(wb_idx) == i) && m_live[i] && !m_rchg[i];
        k = m_live[i] && ((cmt_vld && int'(cmt_idx) == i) || squash_mask[i]);
        if (w) delta += RB;
        if (k) begin
          delta -= HB + ((m_rchg[i] || w) ? RB : 0);
          m_live[i] = 0; m_rchg[i] = 0;
        end else if (w) m_rchg[i] = 1;
      end
      if (disp_req && !stl && !old_live[disp_idx]) begin
        delta += chg;
        m_live[disp_idx] = 1;
        m_rchg[disp_idx] = cfg_conservative;
      end
      m_cnt += delta;
    end
    @(posedge clk);
    @(negedge clk);
    disp_req = 0; wb_vld = 0; cmt_vld = 0; squash_mask = '0; flush_all = 0;
  endtask

  task automatic disp(int i);  disp_req = 1; disp_idx = IW'(i); endtask
  task automatic wb(int i);    wb_vld = 1;   wb_idx = IW'(i);   endtask
  task automatic cmt(int i);   cmt_vld = 1;  cmt_idx = IW'(i);  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_live[i] = 0; m_rchg[i] = 0; end
    cfg_bound = CW'(2047);
    repeat (2) @(negedge clk);
    rst_n = 1;
    check("R1", int'(vuln_count), 0);
    tick("R1");

    disp(0); tick("R2"); check("R2", int'(vuln_count), 64);
    wb(0);   tick("R4"); check("R4", int'(vuln_count), 128);
    wb(0);   tick("R4"); check("R4 repeat", int'(vuln_count), 128);
    wb(5);   tick("R10"); check("R10 wb idle", int'(vuln_count), 128);
    disp(0); tick("R10"); check("R10 disp live", int'(vuln_count), 128);
    disp(1); tick("R2"); check("R2", int'(vuln_count), 192);
    cmt(0);  tick("R5"); check("R5", int'(vuln_count), 64);
    cmt(3);  tick("R10"); check("R10 cmt idle", int'(vuln_count), 64);

    cfg_bound = CW'(128);
    disp(2); tick("R7"); check("R7 equal", int'(vuln_count), 128);
    disp(3); check("R7 stall", int'(disp_stall), 1);
    tick("R7"); check("R7 stalled", int'(vuln_count), 128);
    squash_mask = N'(16'h0006); tick("R6"); check("R6", int'(vuln_count), 0);

    cfg_bound = CW'(256); cfg_conservative = 1;
    disp(4); tick("R3"); check("R3", int'(vuln_count), 128);
    wb(4);   tick("R11"); check("R11", int'(vuln_count), 128);
    disp(5); tick("R3"); check("R3", int'(vuln_count), 256);
    disp(6); tick("R7"); check("R11 bound", int'(vuln_count), 256);
    cmt(4);  tick("R5"); check("R5 full", int'(vuln_count), 128);

    cfg_bound = CW'(2047); cfg_conservative = 0;
    disp(8); tick("R8"); check("R8", int'(vuln_count), 192);
    disp(9); wb(8); cmt(5); tick("R8"); check("R8 mixed", int'(vuln_count), 192);
    wb(9); cmt(9); tick("R8"); check("R8 wb+cmt", int'(vuln_count), 128);
    flush_all = 1; disp(10); tick("R9"); check("R9", int'(vuln_count), 0);
    cmt(8); tick("R9"); check("R9 cleared", int'(vuln_count), 0);

    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 64) == 0) cfg_bound = CW'($urandom % 2100);
      if (($urandom % 128) == 0) cfg_conservative = ~cfg_conservative;
      if (($urandom % 2) == 0) disp(int'($urandom % N));
      if (($urandom % 3) == 0) wb(int'($urandom % N));
      if (($urandom % 3) == 0) cmt(int'($urandom % N));
      if (($urandom % 16) == 0) squash_mask = N'($urandom);
      if (($urandom % 300) == 0) flush_all = 1;
      tick("R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule